// File: doc/BRIEF.md
# Stream Memory Address Generator

This block expands a single stream memory command into the full sequence of single-word addresses that the memory system must visit. A command names a base address, a record length, a record count and a mode. In strided mode, consecutive records begin a fixed stride apart. In indexed mode, the start of each record is taken from a local FIFO of record indices, which supports gathers and scatters. The block issues addresses only. Data, caching and address translation belong to other blocks.

Each output beat carries up to `LANES` word addresses and a per-lane valid mask. The block drives its output on a valid/ready handshake, so it can keep issuing a long stream without waiting for data to return. After the last beat of the stream is accepted, the block pulses `done` for one cycle and becomes ready for the next command.

Top module: `stream_addr_gen`

## Requirements
- R1: `cmd_ready` is high exactly while the block is idle, and a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. While a stream is in progress, `cmd_valid` has no effect on the addresses being issued.
- R2: In strided mode (`cmd_mode` = 0), record k (counting from 0) covers `cmd_len` consecutive words starting at `cmd_base + k*cmd_stride`, modulo 2^ADDR_W.
- R3: In indexed mode (`cmd_mode` = 1), one index is taken from the FIFO for each record, in order, and record k starts at `cmd_base + index_k*cmd_len`.
- R4: A beat never crosses a record boundary. Lane i of `out_addr` occupies bits [i*ADDR_W +: ADDR_W], lane 0 holds the lowest-ordered word, and `out_mask` has its low n bits set, where n is min(LANES, words left in the record).
- R5: While `out_valid` is high and `out_ready` is low, the beat's addresses and mask hold steady and the stream does not advance.
- R6: In indexed mode, no beat of a record is offered until that record's index has been taken. `idx_ready` is high only while a record is waiting for its index.
- R7: `done` is high for exactly one cycle, in the cycle after the final beat is accepted. In that cycle the block is idle.
- R8: A command with a record count of zero or a record length of zero issues no beats and pulses `done` in the cycle after it is accepted.
- R9: After reset, `out_valid`, `done` and `idx_ready` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_mode | input | 1 | 0 strided, 1 indexed |
| cmd_base | input | ADDR_W | Stream base word address |
| cmd_stride | input | ADDR_W | Distance between record starts (strided mode) |
| cmd_len | input | LEN_W | Words per record |
| cmd_count | input | CNT_W | Number of records |
| idx_valid | input | 1 | Index FIFO not empty |
| idx_ready | output | 1 | Index taken this cycle |
| idx_data | input | IDX_W | Record index |
| out_valid | output | 1 | Beat offered |
| out_ready | input | 1 | Beat accepted |
| out_addr | output | LANES*ADDR_W | Lane word addresses |
| out_mask | output | LANES | Lane valid mask |
| done | output | 1 | Stream finished pulse |

## Verification
The bench builds the block with four lanes, 32-bit addresses and 8-bit record lengths. With four lanes, a record length of 1, 3, 5, 6, 9 or 13 produces every partial-mask width as well as records that take several beats. Thirty-two-bit addresses let a stream placed near the top of the space wrap through zero. The 16-bit index width, combined with indices scattered below 64, keeps every indexed start distinct, so a misordered or skipped index shows up as a wrong address.

// File: rtl/sag_pkg.sv
`timescale 1ns/1ps
package sag_pkg;
    typedef enum logic {
        MODE_STRIDE = 1'b0,
        MODE_INDEX  = 1'b1
    } sag_mode_e;
endpackage

// File: rtl/sag_lane_gen.sv
`timescale 1ns/1ps
// Expands the current record position into one beat of lane addresses.
module sag_lane_gen #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0]       rec_start,
    input  logic [LEN_W-1:0]        word_off,
    input  logic [LEN_W-1:0]        rec_len,
    output logic [LANES*ADDR_W-1:0] lane_addr,
    output logic [LANES-1:0]        lane_mask,
    output logic                    last_beat
);
    localparam int SUM_W = LEN_W + 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SUM_W-1:0] pos;
        assign pos = {1'b0, word_off} + SUM_W'(i);
        assign lane_mask[i] = pos < {1'b0, rec_len};
        assign lane_addr[i*ADDR_W +: ADDR_W] = rec_start + ADDR_W'(pos);
    end

    assign last_beat = ({1'b0, word_off} + SUM_W'(LANES)) >= {1'b0, rec_len};
endmodule

// File: rtl/sag_rec_addr.sv
`timescale 1ns/1ps
// Record start arithmetic: indexed start and next strided start.
module sag_rec_addr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int IDX_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [ADDR_W-1:0] cur_start,
    input  logic [IDX_W-1:0]  index,
    input  logic [LEN_W-1:0]  rec_len,
    output logic [ADDR_W-1:0] index_start,
    output logic [ADDR_W-1:0] stride_next
);
    localparam int PROD_W = IDX_W + LEN_W;

    logic [PROD_W-1:0] scaled;
    assign scaled      = PROD_W'(index) * PROD_W'(rec_len);
    assign index_start = base + ADDR_W'(scaled);
    assign stride_next = cur_start + stride;
endmodule

// File: rtl/stream_addr_gen.sv
`timescale 1ns/1ps
module stream_addr_gen
    import sag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4,
    parameter int LEN_W  = 8,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic                    cmd_mode,
    input  logic [ADDR_W-1:0]       cmd_base,
    input  logic [ADDR_W-1:0]       cmd_stride,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [CNT_W-1:0]        cmd_count,
    input  logic                    idx_valid,
    output logic                    idx_ready,
    input  logic [IDX_W-1:0]        idx_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*ADDR_W-1:0] out_addr,
    output logic [LANES-1:0]        out_mask,
    output logic                    done
);
    typedef struct packed {
        logic              busy;
        sag_mode_e         mode;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] stride;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] start;
        logic              have;
        logic [LEN_W-1:0]  off;
        logic              done;
    } sag_state_t;

    sag_state_t s_q, s_d;

    logic              last_beat;
    logic [ADDR_W-1:0] index_start;
    logic [ADDR_W-1:0] stride_next;

    sag_lane_gen #(.ADDR_W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W)) u_lanes (
        .rec_start (s_q.start),
        .word_off  (s_q.off),
        .rec_len   (s_q.len),
        .lane_addr (out_addr),
        .lane_mask (out_mask),
        .last_beat (last_beat)
    );

    sag_rec_addr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_rec (
        .base        (s_q.base),
        .stride      (s_q.stride),
        .cur_start   (s_q.start),
        .index       (idx_data),
        .rec_len     (s_q.len),
        .index_start (index_start),
        .stride_next (stride_next)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        cmd_ready = !s_q.busy;
        out_valid = s_q.busy && s_q.have;
        idx_ready = s_q.busy && (s_q.mode == MODE_INDEX) && !s_q.have;
        done      = s_q.done;

        if (cmd_valid && cmd_ready) begin
            s_d.mode   = sag_mode_e'(cmd_mode);
            s_d.base   = cmd_base;
            s_d.stride = cmd_stride;
            s_d.len    = cmd_len;
            s_d.left   = cmd_count;
            s_d.start  = cmd_base;
            s_d.off    = '0;
            s_d.have   = (sag_mode_e'(cmd_mode) == MODE_STRIDE);
            if (cmd_count == '0 || cmd_len == '0) begin
                s_d.busy = 1'b0;
                s_d.have = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
            end
        end

        if (idx_ready && idx_valid) begin
            s_d.start = index_start;
            s_d.have  = 1'b1;
        end

        if (out_valid && out_ready) begin
            if (last_beat) begin
                s_d.off = '0;
                if (s_q.left == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.have = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.left = s_q.left - CNT_W'(1);
                    if (s_q.mode == MODE_STRIDE) begin
                        s_d.start = stride_next;
                    end else begin
                        s_d.have = 1'b0;
                    end
                end
            end else begin
                s_d.off = s_q.off + LEN_W'(LANES);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sag_checker.sv
`timescale 1ns/1ps
module sag_checker #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_ready,
    input logic                    idx_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*ADDR_W-1:0] out_addr,
    input logic [LANES-1:0]        out_mask,
    input logic                    done
);
    assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_mask));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready && !out_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !out_valid && !idx_ready);

    assert_mask_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_mask[0] && ((out_mask & (out_mask + LANES'(1))) == '0));

    assert_index_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ready |-> !out_valid);
endmodule

bind stream_addr_gen sag_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_sag_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .idx_ready (idx_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_mask  (out_mask),
    .done      (done)
);

// File: tb/stream_addr_gen_bench.sv
`timescale 1ns/1ps
module stream_addr_gen_bench;
    localparam int ADDR_W = 32;
    localparam int LANES  = 4;
    localparam int LEN_W  = 8;
    localparam int CNT_W  = 16;
    localparam int IDX_W  = 16;

    // Vector table: mode, base, stride, record length, record count, stall pattern
    localparam int NV = 6;
    localparam int          V_MODE [NV] = '{0, 0, 0, 1, 1, 0};
    localparam logic [31:0] V_BASE [NV] = '{32'd100, 32'h1000, 32'd50, 32'd200, 32'd0, 32'hFFFF_FFF0};
    localparam logic [31:0] V_STR  [NV] = '{32'd10, 32'd0, 32'd2, 32'd0, 32'd0, 32'd8};
    localparam int          V_LEN  [NV] = '{3, 4, 9, 5, 1, 6};
    localparam int          V_CNT  [NV] = '{4, 2, 3, 4, 6, 3};
    localparam int          V_PAT  [NV] = '{0, 1, 2, 1, 3, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                    cmd_valid = 1'b0;
    logic                    cmd_ready;
    logic                    cmd_mode = 1'b0;
    logic [ADDR_W-1:0]       cmd_base = '0;
    logic [ADDR_W-1:0]       cmd_stride = '0;
    logic [LEN_W-1:0]        cmd_len = '0;
    logic [CNT_W-1:0]        cmd_count = '0;
    logic                    idx_valid = 1'b0;
    logic                    idx_ready;
    logic [IDX_W-1:0]        idx_data = '0;
    logic                    out_valid;
    logic                    out_ready = 1'b0;
    logic [LANES*ADDR_W-1:0] out_addr;
    logic [LANES-1:0]        out_mask;
    logic                    done;

    stream_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES), .LEN_W(LEN_W),
                      .CNT_W(CNT_W), .IDX_W(IDX_W)) u_stream_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mode(cmd_mode),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_len(cmd_len),
        .cmd_count(cmd_count),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_data(idx_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_mask(out_mask), .done(done)
    );

    int errors = 0;
    int checks = 0;
    int wd = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int idx_of(input int k);
        return (k * 13 + 5) % 64;
    endfunction

    function automatic bit ready_pat(input int pat, input int cyc);
        case (pat)
            1:       return (cyc % 3) != 0;
            2:       return (cyc % 2) == 0;
            3:       return (cyc % 5) >= 2;
            default: return 1'b1;
        endcase
    endfunction

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL R7 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Issue one command and check every beat against the stream model.
    task automatic run_stream(input int mode, input logic [31:0] base, input logic [31:0] stride,
                              input int len, input int nrec, input int pat,
                              input bit starve, input bit junk);
        int k = 0;
        int w = 0;
        int ip = 0;
        int cyc = 0;
        bit busy_ok = 1'b1;
        bit early_done = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready before command", cmd_ready, 1);
        cmd_mode = mode[0]; cmd_base = base; cmd_stride = stride;
        cmd_len = LEN_W'(len); cmd_count = CNT_W'(nrec); cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        if (nrec == 0 || len == 0) begin
            @(negedge clk);
            chk(done == 1'b1, "R8", "done after empty command", done, 1);
            chk(out_valid == 1'b0, "R8", "no beat for empty command", out_valid, 0);
            @(negedge clk);
            chk(done == 1'b0, "R7", "done one cycle", done, 0);
            return;
        end
        while (k < nrec && cyc < 3000) begin
            bit fin;
            @(negedge clk);
            cyc++;
            out_ready = ready_pat(pat, cyc);
            idx_valid = (mode == 1) && (ip < nrec) && !(starve && (cyc % 8) < 5);
            idx_data  = IDX_W'(idx_of(ip));
            cmd_valid = junk;
            cmd_base  = 32'hDEAD_0000; cmd_len = 8'd2; cmd_count = 16'd1;
            if (cmd_ready) busy_ok = 1'b0;
            if (done) early_done = 1'b1;
            if (mode == 1 && ip <= k)
                chk(out_valid == 1'b0, "R6", "beat before its index", out_valid, 0);
            fin = 1'b0;
            if (out_valid) begin
                logic [31:0] start;
                int n;
                bit ok = 1'b1;
                logic [31:0] bad_a = '0;
                logic [31:0] exp_a = '0;
                start = (mode == 1) ? base + 32'(idx_of(k) * len) : base + 32'(k) * stride;
                n = (len - w < LANES) ? len - w : LANES;
                chk(out_mask == LANES'((1 << n) - 1), "R4", "lane mask", out_mask, (1 << n) - 1);
                for (int l = 0; l < n; l++) begin
                    if (out_addr[l*ADDR_W +: ADDR_W] != start + 32'(w + l)) begin
                        if (ok) begin
                            bad_a = out_addr[l*ADDR_W +: ADDR_W];
                            exp_a = start + 32'(w + l);
                        end
                        ok = 1'b0;
                    end
                end
                chk(ok, (mode == 1) ? "R3" : "R2", out_ready ? "beat address" : "R5 held beat address",
                    bad_a, exp_a);
                if (out_ready) begin
                    w += LANES;
                    if (w >= len) begin
                        w = 0;
                        k++;
                        if (k == nrec) fin = 1'b1;
                    end
                end
            end
            if (idx_valid && idx_ready) ip++;
            if (fin) cmd_valid = 1'b0;
        end
        chk(busy_ok, "R1", "cmd_ready low while streaming", !busy_ok, 0);
        chk(!early_done, "R7", "no done before final beat", early_done, 0);
        @(negedge clk);
        cmd_valid = 1'b0; out_ready = 1'b0; idx_valid = 1'b0;
        chk(done == 1'b1, "R7", "done after final beat", done, 1);
        chk(cmd_ready == 1'b1, "R1", "idle after final beat", cmd_ready, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done one cycle", done, 0);
        chk(out_valid == 1'b0, "R7", "no beat after done", out_valid, 0);
    endtask

    initial begin
        // R9: state while held in reset and just after release
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        chk(done == 1'b0, "R9", "done after reset", done, 0);
        chk(idx_ready == 1'b0, "R9", "idx_ready after reset", idx_ready, 0);
        chk(cmd_ready == 1'b1, "R9", "cmd_ready after reset", cmd_ready, 1);

        // Table-driven streams (R2, R3, R4, R5, R7)
        for (int v = 0; v < NV; v++) begin
            run_stream(V_MODE[v], V_BASE[v], V_STR[v], V_LEN[v], V_CNT[v], V_PAT[v], 1'b0, 1'b0);
        end

        // R8: zero records and zero length
        run_stream(0, 32'd500, 32'd4, 3, 0, 0, 1'b0, 1'b0);
        run_stream(1, 32'd500, 32'd4, 0, 5, 0, 1'b0, 1'b0);

        // R6 and R1: starved index FIFO with a competing command held high
        run_stream(1, 32'd4000, 32'd0, 6, 5, 1, 1'b1, 1'b1);

        // R4 and R2: long records with back-pressure, competing command
        run_stream(0, 32'd7, 32'd20, 13, 3, 3, 1'b0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule